// File: doc/BRIEF.md
# Shift-and-Add Inverse Cosine Transform Datapath

This block is the arithmetic core of an eight-point, one-dimensional inverse cosine transform approximation on 10-bit two's-complement words. It has no multiplier. The transform is built from shifts by one bit, additions and subtractions. These run as in-place passes over a single eight-entry register file, through a three-stage register pipeline. An external sequencer supplies a fresh control word every cycle, so every register moves on every clock. The block has no stall and no back-pressure. A word on `din` is taken only in the cycle the control word writes it. A result on `dout` is valid only in the cycle the sequencer expects it.

Each cycle, two words are read from the register file and each passes through its own operand shifter into the stage-0 registers. The adder/subtractor combines them into the stage-1 register. A third shifter feeds the stage-2 register, which drives `dout`. The stage-2 value can also be written back into the register file. A word read in one cycle can therefore be replaced by its new value three clock edges later, and no second buffer array is needed. During loading, the sequencer selects `din` as the write source for eight cycles in a row, one coefficient per cycle. During draining, it routes the eight results through the stage-2 register, one per cycle.

Top module: `idct_shift_add_dp`

## Requirements
- R1: While `rst_n` is low, all eight register-file entries and all pipeline registers are zero, so `dout` reads 0 and every entry later reads back as 0.
- R2: With `wr_en` high, the selected write data lands in entry `wr_addr` at the rising edge. The two read ports `rd_a` and `rd_b` address any entries independently in the same cycle.
- R3: A read of an address in the same cycle that it is written returns the value held before that edge. There is no bypass.
- R4: Each shift code (`sh_a`, `sh_b`, `sh_c`) selects one of four functions. 00 passes the word. 01 gives zero. 10 shifts left one place, dropping bit 9 and filling bit 0 with zero. 11 shifts right one place and copies bit 9 into the vacated bit.
- R5: With `sub` = 0 the adder forms stage0a + stage0b. With `sub` = 1 it forms stage0a − stage0b. Both results wrap modulo 1024 without saturation.
- R6: A word read in cycle n appears on `dout` after the third rising edge. The pipeline is read and shift, then add or subtract, then shift again.
- R7: `wr_sel` = 0 writes `din`. `wr_sel` = 1 writes the current stage-2 value (the word on `dout`) and ignores `din`.
- R8: With `wr_en` low, no entry changes, whatever `wr_addr`, `wr_sel` and `din` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 10 | External coefficient word |
| wr_en | input | 1 | Register-file write enable |
| wr_sel | input | 1 | Write source: 0 = din, 1 = stage-2 register |
| wr_addr | input | 3 | Register-file write address |
| rd_a | input | 3 | Read address, operand A |
| rd_b | input | 3 | Read address, operand B |
| sh_a | input | 2 | Shift code for operand A |
| sh_b | input | 2 | Shift code for operand B |
| sub | input | 1 | 0 = add, 1 = subtract |
| sh_c | input | 2 | Shift code for the result |
| dout | output | 10 | Stage-2 register contents |

## Verification
Eight loaded words that mix positive, negative and extreme values are each read back. This separates address decoding from data errors. Every shift code is applied to one positive and one negative word, and left and right shifts of -512 are applied at the result stage. These cases tell sign fill apart from zero fill, and show whether the top bit is dropped. Add and subtract cases that cross +511 and −512 expose any saturation or carry-in fault. Other directed sequences cover a write and a read of the same address in one cycle, a write-back from the stage-2 register while `din` carries a decoy word, and an address change observed edge by edge to pin the three-edge latency.

// File: rtl/idct_pkg.sv
package idct_pkg;
  localparam int WORD_W = 10;
  localparam int ENTRIES = 8;
  localparam int ADDR_W = $clog2(ENTRIES);

  typedef enum logic [1:0] {
    SH_PASS  = 2'b00,
    SH_ZERO  = 2'b01,
    SH_LEFT  = 2'b10,
    SH_RIGHT = 2'b11
  } shift_op_e;
endpackage

// File: rtl/idct_regfile.sv
module idct_regfile #(
  parameter int W = 10,
  parameter int N = 8,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_a,
  input  logic [AW-1:0] rd_b,
  output logic [W-1:0]  q_a,
  output logic [W-1:0]  q_b
);
  logic [N-1:0][W-1:0] mem;

  for (genvar i = 0; i < N; i++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[i] <= '0;
      else if (wr_en && wr_addr == AW'(i))
        mem[i] <= wr_data;
    end
  end

  assign q_a = mem[rd_a];
  assign q_b = mem[rd_b];

  // R2: a write is visible in the addressed entry after the edge
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(wr_addr)] == $past(wr_data));

  // R8: a disabled write leaves every entry untouched
  assert_hold_without_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mem));
endmodule

// File: rtl/idct_shifter.sv
module idct_shifter
  import idct_pkg::*;
#(
  parameter int W = 10
) (
  input  logic [1:0]   op,
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (shift_op_e'(op))
      SH_PASS:  y = x;
      SH_ZERO:  y = '0;
      SH_LEFT:  y = {x[W-2:0], 1'b0};
      SH_RIGHT: y = {x[W-1], x[W-1:1]};
      default:  y = x;
    endcase
  end
endmodule

// File: rtl/idct_addsub.sv
module idct_addsub #(
  parameter int W = 10
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] y
);
  logic [W-1:0] b_x;

  assign b_x = b ^ {W{sub}};
  assign y   = a + b_x + W'(sub);
endmodule

// File: rtl/idct_shift_add_dp.sv
module idct_shift_add_dp
  import idct_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] din,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] rd_a,
  input  logic [ADDR_W-1:0] rd_b,
  input  logic [1:0]        sh_a,
  input  logic [1:0]        sh_b,
  input  logic              sub,
  input  logic [1:0]        sh_c,
  output logic [WORD_W-1:0] dout
);
  logic [WORD_W-1:0] q_a, q_b, op_a, op_b, sum, post;
  logic [WORD_W-1:0] r0a, r0b, r1, r2, wdata;

  assign wdata = wr_sel ? r2 : din;

  idct_regfile #(.W(WORD_W), .N(ENTRIES)) u_rf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wdata), .rd_a(rd_a), .rd_b(rd_b), .q_a(q_a), .q_b(q_b)
  );

  idct_shifter #(.W(WORD_W)) u_sh_a (.op(sh_a), .x(q_a), .y(op_a));
  idct_shifter #(.W(WORD_W)) u_sh_b (.op(sh_b), .x(q_b), .y(op_b));
  idct_addsub  #(.W(WORD_W)) u_alu  (.a(r0a), .b(r0b), .sub(sub), .y(sum));
  idct_shifter #(.W(WORD_W)) u_sh_c (.op(sh_c), .x(r1), .y(post));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r0a <= '0;
      r0b <= '0;
      r1  <= '0;
      r2  <= '0;
    end else begin
      r0a <= op_a;
      r0b <= op_b;
      r1  <= sum;
      r2  <= post;
    end
  end

  assign dout = r2;

  // R4: the zero code clears the result stage
  assert_zero_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_c == 2'b01) |=> dout == '0);

  // R5: add and subtract wrap modulo 2^W
  assert_add_wraps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sub |=> (r1 - $past(r0b)) == $past(r0a));
  assert_sub_wraps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sub |=> (r1 + $past(r0b)) == $past(r0a));

  // R6: stage 1 reaches the output one edge later under pass
  assert_stage_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_c == 2'b00) |=> dout == $past(r1));
endmodule

// File: tb/idct_shift_add_dp_test.sv
module idct_shift_add_dp_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic [9:0] din = '0;
  logic       wr_en = 1'b0, wr_sel = 1'b0, sub = 1'b0;
  logic [2:0] wr_addr = '0, rd_a = '0, rd_b = '0;
  logic [1:0] sh_a = 2'b00, sh_b = 2'b01, sh_c = 2'b00;
  logic [9:0] dout;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [9:0] model [8];

  always #10 clk = ~clk;

  idct_shift_add_dp uut (
    .clk(clk), .rst_n(rst_n), .din(din), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_addr(wr_addr), .rd_a(rd_a), .rd_b(rd_b), .sh_a(sh_a), .sh_b(sh_b),
    .sub(sub), .sh_c(sh_c), .dout(dout)
  );

  function automatic logic [9:0] shf(input logic [1:0] op, input logic [9:0] v);
    case (op)
      2'b00: return v;
      2'b01: return 10'd0;
      2'b10: return {v[8:0], 1'b0};
      default: return {v[9], v[9:1]};
    endcase
  endfunction

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] a, input logic [2:0] b, input logic [1:0] sa,
                        input logic [1:0] sb, input logic s, input logic [1:0] sc,
                        output logic [9:0] r);
    wr_en = 0; rd_a = a; rd_b = b; sh_a = sa; sh_b = sb; sub = s; sh_c = sc;
    repeat (3) @(negedge clk);
    r = dout;
  endtask

  function automatic logic [9:0] expect_op(input logic [2:0] a, input logic [2:0] b,
      input logic [1:0] sa, input logic [1:0] sb, input logic s, input logic [1:0] sc);
    logic [9:0] x, y;
    x = shf(sa, model[a]); y = shf(sb, model[b]);
    return shf(sc, s ? x - y : x + y);
  endfunction

  task automatic peek(input logic [2:0] a, output logic [9:0] r);
    run_op(a, 3'd0, 2'b00, 2'b01, 1'b0, 2'b00, r);
  endtask

  task automatic t_reset;
    logic [9:0] r;
    #1 rst_n = 0;
    repeat (2) @(negedge clk);
    chk("R1 dout in reset", dout, 10'd0);
    rst_n = 1;
    for (int i = 0; i < 8; i++) begin
      model[i] = '0;
      peek(3'(i), r);
      chk("R1 entry cleared", r, 10'd0);
    end
  endtask

  task automatic t_load;
    logic [9:0] vals [8] = '{10'h1A5, 10'h3F0, 10'h07C, 10'h200,
                             10'h1FF, 10'h001, 10'h2C8, 10'h133};
    logic [9:0] r;
    for (int i = 0; i < 8; i++) begin
      wr_en = 1; wr_sel = 0; wr_addr = 3'(i); din = vals[i];
      @(negedge clk);
      model[i] = vals[i];
    end
    wr_en = 0;
    for (int i = 7; i >= 0; i--) begin
      peek(3'(i), r);
      chk("R2 load and read back", r, model[i]);
    end
  endtask

  task automatic t_shifts;
    logic [9:0] r;
    for (int op = 0; op < 4; op++) begin
      for (int e = 0; e < 2; e++) begin
        run_op(3'(e), 3'd2, 2'(op), 2'b01, 1'b0, 2'b00, r);
        chk("R4 operand shift code", r, expect_op(3'(e), 3'd2, 2'(op), 2'b01, 1'b0, 2'b00));
      end
    end
    run_op(3'd3, 3'd0, 2'b00, 2'b01, 1'b0, 2'b10, r);
    chk("R4 left drops top bit", r, 10'h000);
    run_op(3'd3, 3'd0, 2'b00, 2'b01, 1'b0, 2'b11, r);
    chk("R4 right copies sign", r, 10'h300);
    run_op(3'd2, 3'd1, 2'b01, 2'b11, 1'b0, 2'b00, r);
    chk("R4 operand B right shift", r, 10'h3F8);
  endtask

  task automatic t_arith;
    logic [9:0] r;
    run_op(3'd4, 3'd5, 2'b00, 2'b00, 1'b0, 2'b00, r);
    chk("R5 add wraps past +511", r, 10'h200);
    run_op(3'd3, 3'd5, 2'b00, 2'b00, 1'b1, 2'b00, r);
    chk("R5 subtract wraps past -512", r, 10'h1FF);
    run_op(3'd2, 3'd0, 2'b00, 2'b00, 1'b1, 2'b00, r);
    chk("R5 subtract negative result", r, 10'h07C - 10'h1A5);
    run_op(3'd6, 3'd7, 2'b10, 2'b11, 1'b1, 2'b11, r);
    chk("R2 R5 mixed dual read", r, expect_op(3'd6, 3'd7, 2'b10, 2'b11, 1'b1, 2'b11));
  endtask

  task automatic t_latency;
    logic [9:0] r;
    peek(3'd4, r);
    rd_a = 3'd6;
    @(negedge clk); chk("R6 edge 1 still old", dout, model[4]);
    @(negedge clk); chk("R6 edge 2 still old", dout, model[4]);
    @(negedge clk); chk("R6 edge 3 new word", dout, model[6]);
  endtask

  task automatic t_writeback;
    logic [9:0] r, v;
    run_op(3'd0, 3'd2, 2'b00, 2'b00, 1'b0, 2'b00, v);
    wr_en = 1; wr_sel = 1; wr_addr = 3'd5; din = 10'h2AA;
    @(negedge clk);
    wr_en = 0;
    model[5] = model[0] + model[2];
    chk("R7 dout before write-back", v, model[5]);
    peek(3'd5, r);
    chk("R7 stage-2 written, din ignored", r, model[5]);
  endtask

  task automatic t_no_bypass;
    logic [9:0] r, old;
    old = model[2];
    rd_a = 3'd2; sh_a = 2'b00; sh_b = 2'b01; sub = 0; sh_c = 2'b00;
    wr_en = 1; wr_sel = 0; wr_addr = 3'd2; din = 10'h155;
    @(negedge clk);
    wr_en = 0; sh_a = 2'b01;
    model[2] = 10'h155;
    repeat (2) @(negedge clk);
    chk("R3 same-cycle read gets old", dout, old);
    peek(3'd2, r);
    chk("R3 new value stored", r, 10'h155);
  endtask

  task automatic t_disabled;
    logic [9:0] r;
    wr_en = 0; wr_sel = 0; wr_addr = 3'd3; din = 10'h0F0;
    repeat (2) @(negedge clk);
    wr_sel = 1;
    @(negedge clk);
    peek(3'd3, r);
    chk("R8 disabled write ignored", r, model[3]);
  endtask

  initial begin
    t_reset();
    t_load();
    t_shifts();
    t_arith();
    t_latency();
    t_writeback();
    t_no_bypass();
    t_disabled();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule